// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block keeps a free-running 32-bit count of seconds and raises an interrupt when that count reaches a programmable match value. A prescaler divides the system clock by `CLK_PER_SEC` to make a one-second tick. Each tick advances the count, which wraps modulo 2^32. Software reaches the block through a single-cycle register port. The port has a strobe, a write flag, a byte address and a 32-bit write word. Read data comes back registered.

Software can set the running count and can program the match value. It can gate the interrupt with a one-bit mask, read the raw and the masked alarm status, and clear the alarm by writing to a clear register. An identification region at the top of the 4 KiB window returns eight fixed bytes, one per word. The alarm is checked whenever the count or the match value changes, whether by a tick, a load or a match write. The equality is a plain 32-bit compare, so a match value below the current count fires once the count has wrapped.

Top module: `sec_alarm_rtc`

## Requirements
- R1: After reset the count, match, load, mask and raw status registers are all 0, `irqOut` is low and `accRdata` is 0.
- R2: The count increases by exactly one every `CLK_PER_SEC` clock cycles and wraps from 0xFFFFFFFF to 0.
- R3: A write to the load register (word offset 2, byte 0x08) sets the count to the written value at that edge and restarts the prescaler. The next increment comes `CLK_PER_SEC` cycles after the load edge. Reading offset 0x08 returns the last value written there. Reading offset 0x00 returns the current count.
- R4: A write to the match register (byte 0x04) stores the value. If the value equals the current count, the raw status (byte 0x14, bit 0) is set at that same edge.
- R5: The raw status is set when a tick moves the count onto the match value, including after a wrap. It is also set when a load writes a value equal to the match value.
- R6: Only bit 0 of the mask register (byte 0x10) is kept. `irqOut` equals raw status AND mask. The masked status register (byte 0x18) reads the same value.
- R7: A write of any value to the clear register (byte 0x1C) clears the raw status and drops `irqOut`. If an alarm event falls on the same edge as the clear, the event wins and the status stays set.
- R8: The control register (byte 0x0C) always reads 1, and writes to it are ignored. Writes to offsets 0x00, 0x14 and 0x18 change nothing. Reading offset 0x1C returns 0.
- R9: Reads at bytes 0xFE0, 0xFE4 … 0xFFC return, in address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with the upper bits zero.
- R10: `accRdata` is loaded on the edge that takes a read strobe. It holds its value through idle cycles and writes until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | One-cycle access strobe |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | ADDR_W (12) | Byte address within the window; bits 1:0 ignored |
| accWdata | input | DATA_W (32) | Write data |
| accRdata | output | DATA_W (32) | Registered read data |
| irqOut | output | 1 | Alarm interrupt, raw status AND mask |

## Verification
The assertions check several rules on every cycle. The count only holds or steps by one unless a load forces it. A load takes its written value. A match write equal to the count sets the status at once. The status rises only while count and match are equal. The interrupt never rises without raw status. Read data changes only after a read. The bench scenarios show the rest: the exact cycle of each tick after a prescaler restart, firing across the wrap, the clear colliding with a tick-driven match, the masking of the interrupt, writes to read-only offsets having no effect, and the identification byte order.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  // Word offsets within the register window (address bits 4:2).
  typedef enum logic [2:0] {
    REG_COUNT = 3'd0,
    REG_MATCH = 3'd1,
    REG_LOAD  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_MASK  = 3'd4,
    REG_RAW   = 3'd5,
    REG_MIS   = 3'd6,
    REG_CLR   = 3'd7
  } regSel_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadCount;
    logic writeMatch;
    logic writeLoadReg;
    logic writeMask;
    logic clearRaw;
  } dpStrobe_t;

  localparam int ID_COUNT = 8;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h31;
      3'd1: b = 8'h10;
      3'd2: b = 8'h14;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_passthru
      assign tick = !restart;
    end else begin : g_divide
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] phase;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          phase <= '0;
        end else if (restart || phase == LAST) begin
          phase <= '0;
        end else begin
          phase <= phase + 1'b1;
        end
      end

      assign tick = (phase == LAST) && !restart;
    end
  endgenerate

endmodule

// File: rtl/sec_rtc_datapath.sv
module sec_rtc_datapath
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CLK_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] matchVal,
  output logic [DATA_W-1:0] loadVal,
  output logic              maskBit,
  output logic              rawBit
);

  logic              secTick;
  logic [DATA_W-1:0] countNext;
  logic [DATA_W-1:0] matchNext;
  logic              alarmEvent;
  logic              alarmHit;

  sec_rtc_prescaler #(.DIV(CLK_PER_SEC)) u_presc (
    .clk     (clk),
    .rstN    (rstN),
    .restart (strb.loadCount),
    .tick    (secTick)
  );

  always_comb begin
    if (strb.loadCount) begin
      countNext = wdata;
    end else if (secTick) begin
      countNext = countVal + 1'b1;
    end else begin
      countNext = countVal;
    end
    matchNext  = strb.writeMatch ? wdata : matchVal;
    alarmEvent = strb.loadCount || strb.writeMatch || secTick;
    alarmHit   = alarmEvent && (countNext == matchNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      matchVal <= '0;
      loadVal  <= '0;
      maskBit  <= 1'b0;
      rawBit   <= 1'b0;
    end else begin
      countVal <= countNext;
      matchVal <= matchNext;
      if (strb.writeLoadReg) loadVal <= wdata;
      if (strb.writeMask)    maskBit <= wdata[0];
      if (alarmHit)           rawBit <= 1'b1;
      else if (strb.clearRaw) rawBit <= 1'b0;
    end
  end

endmodule

// File: rtl/sec_rtc_ctrl.sv
module sec_rtc_ctrl
  import sec_rtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] matchVal,
  input  logic [DATA_W-1:0] loadVal,
  input  logic              maskBit,
  input  logic              rawBit,
  output dpStrobe_t         strb,
  output logic [DATA_W-1:0] accRdata
);

  localparam int HI_W = ADDR_W - 5;

  logic              inRegs;
  logic              inIdBlock;
  regSel_e           sel;
  logic              wrHit;
  logic [DATA_W-1:0] readMux;

  assign inRegs    = (accAddr[ADDR_W-1:5] == HI_W'(0));
  assign inIdBlock = (accAddr[ADDR_W-1:5] == {HI_W{1'b1}});
  assign sel       = regSel_e'(accAddr[4:2]);
  assign wrHit     = accValid && accWrite && inRegs;

  always_comb begin
    strb              = '0;
    strb.loadCount    = wrHit && (sel == REG_LOAD);
    strb.writeLoadReg = wrHit && (sel == REG_LOAD);
    strb.writeMatch   = wrHit && (sel == REG_MATCH);
    strb.writeMask    = wrHit && (sel == REG_MASK);
    strb.clearRaw     = wrHit && (sel == REG_CLR);
  end

  always_comb begin
    readMux = '0;
    if (inIdBlock) begin
      readMux = DATA_W'(idByte(accAddr[4:2]));
    end else if (inRegs) begin
      case (sel)
        REG_COUNT: readMux = countVal;
        REG_MATCH: readMux = matchVal;
        REG_LOAD:  readMux = loadVal;
        REG_CTRL:  readMux = DATA_W'(1);
        REG_MASK:  readMux = DATA_W'(maskBit);
        REG_RAW:   readMux = DATA_W'(rawBit);
        REG_MIS:   readMux = DATA_W'(rawBit & maskBit);
        default:   readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accRdata <= '0;
    end else if (accValid && !accWrite) begin
      accRdata <= readMux;
    end
  end

endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc
  import sec_rtc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int CLK_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWdata,
  output logic [DATA_W-1:0] accRdata,
  output logic              irqOut
);

  dpStrobe_t         strb;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] matchVal;
  logic [DATA_W-1:0] loadVal;
  logic              maskBit;
  logic              rawBit;

  sec_rtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accWrite (accWrite),
    .accAddr  (accAddr),
    .countVal (countVal),
    .matchVal (matchVal),
    .loadVal  (loadVal),
    .maskBit  (maskBit),
    .rawBit   (rawBit),
    .strb     (strb),
    .accRdata (accRdata)
  );

  sec_rtc_datapath #(.DATA_W(DATA_W), .CLK_PER_SEC(CLK_PER_SEC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (accWdata),
    .countVal (countVal),
    .matchVal (matchVal),
    .loadVal  (loadVal),
    .maskBit  (maskBit),
    .rawBit   (rawBit)
  );

  assign irqOut = rawBit & maskBit;

endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [ADDR_W-1:0] accAddr,
  input logic [DATA_W-1:0] accWdata,
  input logic [DATA_W-1:0] accRdata,
  input logic              irqOut,
  input logic [DATA_W-1:0] countVal,
  input logic [DATA_W-1:0] matchVal,
  input logic              rawBit
);

  logic [ADDR_W-3:0] wordIdx;
  logic              loadWr;
  logic              matchWr;
  logic              ctrlRd;
  logic              anyRd;

  assign wordIdx = accAddr[ADDR_W-1:2];
  assign loadWr  = accValid && accWrite && (wordIdx == (ADDR_W-2)'(2));
  assign matchWr = accValid && accWrite && (wordIdx == (ADDR_W-2)'(1));
  assign ctrlRd  = accValid && !accWrite && (wordIdx == (ADDR_W-2)'(3));
  assign anyRd   = accValid && !accWrite;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !loadWr |=> (countVal == $past(countVal)) ||
                (countVal == DATA_W'($past(countVal) + DATA_W'(1))));

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> countVal == $past(accWdata));

  p_match_now_r4: assert property (@(posedge clk) disable iff (!rstN)
    (matchWr && accWdata == countVal) |=> rawBit);

  p_raw_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawBit) |-> countVal == matchVal);

  p_irq_raw_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> rawBit);

  p_ctrl_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd |=> accRdata == DATA_W'(1));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !anyRd |=> $stable(accRdata));

endmodule

bind sec_alarm_rtc sec_rtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .accWrite (accWrite),
  .accAddr  (accAddr),
  .accWdata (accWdata),
  .accRdata (accRdata),
  .irqOut   (irqOut),
  .countVal (countVal),
  .matchVal (matchVal),
  .rawBit   (rawBit)
);

// File: tb/sec_alarm_rtc_tb.sv
module sec_alarm_rtc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;

  localparam logic [11:0] A_COUNT = 12'h000;
  localparam logic [11:0] A_MATCH = 12'h004;
  localparam logic [11:0] A_LOAD  = 12'h008;
  localparam logic [11:0] A_CTRL  = 12'h00C;
  localparam logic [11:0] A_MASK  = 12'h010;
  localparam logic [11:0] A_RAW   = 12'h014;
  localparam logic [11:0] A_MIS   = 12'h018;
  localparam logic [11:0] A_CLR   = 12'h01C;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [0:NVEC-1] = '{
    '{1'b0, A_CTRL,  32'h0,        1'b1, 32'h1,        4'd8},  // R8 control reads 1
    '{1'b1, A_CTRL,  32'h0,        1'b0, 32'h0,        4'd8},  // R8 write ignored
    '{1'b0, A_CTRL,  32'h0,        1'b1, 32'h1,        4'd8},
    '{1'b1, A_MASK,  32'hFFFFFFFE, 1'b0, 32'h0,        4'd6},  // R6 bit0 only
    '{1'b0, A_MASK,  32'h0,        1'b1, 32'h0,        4'd6},
    '{1'b1, A_MASK,  32'hFFFFFFFF, 1'b0, 32'h0,        4'd6},
    '{1'b0, A_MASK,  32'h0,        1'b1, 32'h1,        4'd6},
    '{1'b1, A_LOAD,  32'h00001234, 1'b0, 32'h0,        4'd3},  // R3
    '{1'b0, A_LOAD,  32'h0,        1'b1, 32'h00001234, 4'd3},
    '{1'b0, A_COUNT, 32'h0,        1'b1, 32'h00001234, 4'd3},
    '{1'b0, A_CLR,   32'h0,        1'b1, 32'h0,        4'd8},  // R8 clear reads 0
    '{1'b0, 12'hFE0, 32'h0,        1'b1, 32'h31,       4'd9},  // R9 id bytes
    '{1'b0, 12'hFE4, 32'h0,        1'b1, 32'h10,       4'd9},
    '{1'b0, 12'hFE8, 32'h0,        1'b1, 32'h14,       4'd9},
    '{1'b0, 12'hFEC, 32'h0,        1'b1, 32'h00,       4'd9},
    '{1'b0, 12'hFF0, 32'h0,        1'b1, 32'h0D,       4'd9},
    '{1'b0, 12'hFF4, 32'h0,        1'b1, 32'hF0,       4'd9},
    '{1'b0, 12'hFF8, 32'h0,        1'b1, 32'h05,       4'd9},
    '{1'b0, 12'hFFC, 32'h0,        1'b1, 32'hB1,       4'd9},
    '{1'b1, A_MASK,  32'h0,        1'b0, 32'h0,        4'd6}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid;
  logic        accWrite;
  logic [11:0] accAddr;
  logic [31:0] accWdata;
  logic [31:0] accRdata;
  logic        irqOut;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_alarm_rtc #(.ADDR_W(12), .DATA_W(32), .CLK_PER_SEC(DIV)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accWrite (accWrite),
    .accAddr  (accAddr),
    .accWdata (accWdata),
    .accRdata (accRdata),
    .irqOut   (irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; the access is taken on the next posedge and the
  // task returns at the following negedge.
  task automatic busOp(input logic we, input logic [11:0] a, input logic [31:0] d);
    accValid = 1'b1;
    accWrite = we;
    accAddr  = a;
    accWdata = d;
    @(negedge clk);
    accValid = 1'b0;
    accWrite = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [11:0] a, input logic [31:0] exp);
    busOp(1'b0, a, 32'h0);
    check(req, accRdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; accValid = 1'b0; accWrite = 1'b0; accAddr = '0; accWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irqOut), 32'h0);
    check("R1 rdata", accRdata, 32'h0);
    rdCheck("R1 count", A_COUNT, 32'h0);
    rdCheck("R1 match", A_MATCH, 32'h0);
    rdCheck("R1 load",  A_LOAD,  32'h0);
    rdCheck("R1 mask",  A_MASK,  32'h0);
    rdCheck("R1 raw",   A_RAW,   32'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      busOp(VEC[i].we, VEC[i].addr, VEC[i].data);
      if (VEC[i].chk) check($sformatf("R%0d vec%0d", VEC[i].req, i), accRdata, VEC[i].exp);
    end

    // R10 read data holds across writes and idle cycles
    rdCheck("R10 ctrl", A_CTRL, 32'h1);
    busOp(1'b1, A_MATCH, 32'hABCD0000);
    @(negedge clk);
    check("R10 hold", accRdata, 32'h1);

    // R2/R3 tick spacing after a load restart
    busOp(1'b1, A_LOAD, 32'h100);
    for (int i = 1; i <= 9; i++) begin
      busOp(1'b0, A_COUNT, 32'h0);
      check($sformatf("R2 R3 step%0d", i), accRdata, (i <= 8) ? 32'h100 : 32'h101);
    end

    // R2/R5 wrap and fire on wrap
    busOp(1'b1, A_LOAD, 32'hFFFFFFFF);
    busOp(1'b1, A_MATCH, 32'h0);
    busOp(1'b1, A_MASK, 32'h1);
    busOp(1'b1, A_CLR, 32'h0);
    for (int j = 4; j <= 9; j++) begin
      busOp(1'b0, A_COUNT, 32'h0);
      check($sformatf("R2 wrap%0d", j), accRdata, (j <= 8) ? 32'hFFFFFFFF : 32'h0);
      check($sformatf("R5 irq%0d", j), 32'(irqOut), (j >= 8) ? 32'h1 : 32'h0);
    end
    rdCheck("R6 mis", A_MIS, 32'h1);

    // R7 clear with arbitrary value
    busOp(1'b1, A_CLR, 32'hDEADBEEF);
    check("R7 irq", 32'(irqOut), 32'h0);
    rdCheck("R7 raw", A_RAW, 32'h0);

    // R4 match equal to count fires at once; R6 masking
    busOp(1'b1, A_LOAD, 32'h50);
    busOp(1'b1, A_MATCH, 32'h50);
    check("R4 irq", 32'(irqOut), 32'h1);
    busOp(1'b1, A_CLR, 32'h0);
    busOp(1'b1, A_MASK, 32'h0);
    busOp(1'b1, A_MATCH, 32'h50);
    check("R6 masked irq", 32'(irqOut), 32'h0);
    rdCheck("R6 mis0", A_MIS, 32'h0);
    rdCheck("R4 raw", A_RAW, 32'h1);
    busOp(1'b1, A_MASK, 32'h1);
    check("R6 unmask irq", 32'(irqOut), 32'h1);

    // R5 load equal to match fires
    busOp(1'b1, A_CLR, 32'h0);
    busOp(1'b1, A_LOAD, 32'h50);
    check("R5 load hit", 32'(irqOut), 32'h1);

    // R8 writes to read-only offsets
    busOp(1'b1, A_CLR, 32'h0);
    busOp(1'b1, A_LOAD, 32'h60);
    busOp(1'b1, A_MATCH, 32'h60);
    busOp(1'b1, A_RAW, 32'h0);
    busOp(1'b1, A_MIS, 32'h0);
    busOp(1'b1, A_COUNT, 32'h999);
    rdCheck("R8 count", A_COUNT, 32'h60);
    check("R8 irq", 32'(irqOut), 32'h1);
    rdCheck("R8 raw", A_RAW, 32'h1);

    // R7 alarm event beats clear on the same edge
    busOp(1'b1, A_CLR, 32'h0);
    busOp(1'b1, A_LOAD, 32'h200);
    busOp(1'b1, A_MATCH, 32'h201);
    for (int k = 2; k <= 7; k++) busOp(1'b0, A_CTRL, 32'h0);
    busOp(1'b1, A_CLR, 32'h0);
    check("R7 collide irq", 32'(irqOut), 32'h1);
    rdCheck("R7 collide raw", A_RAW, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule